// File: doc/BRIEF.md
# Multi-Hit Time Digitizer Buffer

This block records the arrival times of edges on sixteen input lines. A free-running coarse counter runs on the block clock. When a line shows a rising edge while the acquisition gate is open, the block captures a timestamp into that line's private buffer. The timestamp holds the current coarse count and a 5-bit fine interpolation value, which is supplied per line from outside. It also holds the underflow and overflow flags of that fine value. Each buffer holds eight hits. After a hit is recorded, the line stays blind for a fixed number of cycles.

The stored hits leave through a valid/ready output stream of 32-bit words. Each accepted word removes one hit. The stream always presents the oldest hit of the lowest-numbered line that has data, so a full readout walks the hits of one line in arrival order and then moves to the next line that holds data. The word for the final stored hit carries an end marker. When nothing is stored, the stream offers a fixed "no data" word. Accepting that word changes nothing.

Back-pressure: `rd_valid` is high in every cycle after reset. A word moves only in a cycle where `rd_ready` is also high, and that transfer happens at the clock edge. While `rd_ready` is low, the offered word stays the same unless a new hit is recorded in that cycle.

Top module: `tdc_multihit`

## Requirements
- R1: While reset is held, and in the cycle after it, every `chan_empty` bit is 1, every `chan_ovf` bit is 0, `wr_pulse` is 0 and `rd_data` equals 32'h8200_0000. `rd_valid` is 0 while reset is held and 1 from the first clock after release.
- R2: A rising edge on `hit_in[i]` (low at one clock edge, high at the next) with the gate open stores a hit for line i. The hit holds the coarse count in effect at that edge and the `fine_in`, `fine_under` and `fine_over` values of line i at that edge. `wr_pulse[i]` is high for exactly the one cycle after that edge, and `chan_empty[i]` goes low.
- R3: An edge seen while `gate_open` is low stores nothing, pulses nothing and does not start the blind window.
- R4: After a recorded edge on line i, edges sampled at the next DEAD_CYCLES clock edges on that line are ignored (default 6). An edge at the edge after that is recorded.
- R5: A line holds at most DEPTH hits (default 8). An edge that finds its buffer full is dropped, no `wr_pulse` is given, and `chan_ovf[i]` becomes 1 and stays 1 until reset. The hits already stored are unchanged.
- R6: The stream offers the oldest hit of the lowest-numbered non-empty line. Each transfer removes exactly that hit.
- R7: Word layout: bit 31 is the last flag and bit 25 is the invalid flag (0 means valid). Bits 21:18 hold the line number, bit 17 the fine overflow flag and bit 16 the fine underflow flag. Bits 15:5 hold the 11-bit coarse count and bits 4:0 the fine value. All other bits are 0.
- R8: Bit 31 is 1 on the word of the only hit still stored, and 0 while more than one hit is stored.
- R9: With every buffer empty, `rd_data` is 32'h8200_0000, and a transfer of it changes no state.
- R10: `chan_empty[i]` is 1 exactly when line i stores no hit.
- R11: The coarse count is 0 in the first cycle after reset, increases by one every clock and wraps from 2047 to 0.
- R12: While `rd_ready` is low and no hit is being recorded, `rd_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one coarse step per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_open | input | 1 | Acquisition gate; edges count only while high |
| hit_in | input | NUM_CH | Line inputs, rising-edge sensitive |
| fine_in | input | NUM_CH*5 | Fine interpolation value, 5 bits per line, line i at [5i+4:5i] |
| fine_under | input | NUM_CH | Fine underflow flag per line |
| fine_over | input | NUM_CH | Fine overflow flag per line |
| rd_valid | output | 1 | Output word offered |
| rd_ready | input | 1 | Consumer accepts the offered word |
| rd_data | output | 32 | Formatted hit word or the no-data word |
| chan_empty | output | NUM_CH | Per-line buffer empty |
| chan_ovf | output | NUM_CH | Per-line sticky lost-hit flag |
| wr_pulse | output | NUM_CH | One-cycle pulse after a line records a hit |

## Verification
A corrupted buffer pointer or count shows at the ports on the next drain, in one of three ways. The line gives the wrong hit, too many or too few words, or its `chan_empty` bit stays wrong once the bench's expected queue for it is empty. A wrong blind-window or edge-detect state shows within DEAD_CYCLES+1 cycles, as a `wr_pulse` that appears or goes missing at the boundary edge. A wrong line priority or end-marker calculation shows on the very next transfer as a mismatched channel field or bit 31. A coarse counter off by any amount shows in the 11-bit time field of the first hit recorded after the fault.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  localparam int COARSE_W    = 11;
  localparam int FINE_W      = 5;
  localparam int CHAN_W      = 4;
  localparam int WORD_W      = 32;
  localparam int BIT_LAST    = 31;
  localparam int BIT_INVALID = 25;
  localparam int CHAN_LSB    = 18;
  localparam int BIT_OVER    = 17;
  localparam int BIT_UNDER   = 16;
  localparam int COARSE_LSB  = 5;

  typedef struct packed {
    logic                over;
    logic                under;
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
  } stamp_t;

  localparam int STAMP_W = $bits(stamp_t);

  function automatic logic [WORD_W-1:0] pack_word(input logic last, input logic bad,
                                                  input logic [CHAN_W-1:0] ch,
                                                  input stamp_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_LAST]                    = last;
    w[BIT_INVALID]                 = bad;
    w[CHAN_LSB +: CHAN_W]          = ch;
    w[BIT_OVER]                    = s.over;
    w[BIT_UNDER]                   = s.under;
    w[COARSE_LSB +: COARSE_W]      = s.coarse;
    w[FINE_W-1:0]                  = s.fine;
    return w;
  endfunction
endpackage

// File: rtl/tdc_edge_arm.sv
`timescale 1ns/1ps
module tdc_edge_arm #(
  parameter int DEAD_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_in,
  input  logic gate_open,
  input  logic fifo_full,
  output logic take,
  output logic drop
);
  localparam int DW = $clog2(DEAD_CYCLES + 1);

  logic          hit_q;
  logic [DW-1:0] dead_cnt;
  logic          rise;
  logic          accept;

  always_comb begin
    rise   = hit_in & ~hit_q;
    accept = rise & gate_open & (dead_cnt == '0);
    take   = accept & ~fifo_full;
    drop   = accept & fifo_full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      dead_cnt <= '0;
    end else begin
      hit_q <= hit_in;
      if (accept)
        dead_cnt <= DW'(DEAD_CYCLES);
      else if (dead_cnt != '0)
        dead_cnt <= dead_cnt - 1'b1;
    end
  end

  generate
    if (DEAD_CYCLES >= 2) begin : g_gap_chk
      assert_rearm_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ##2 !take);
    end
  endgenerate
endmodule

// File: rtl/tdc_hit_fifo.sv
`timescale 1ns/1ps
module tdc_hit_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         one_left
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (count == '0);
    full     = (count == CW'(DEPTH));
    one_left = (count == CW'(1));
    dout     = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_push_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !empty);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/tdc_read_sel.sv
`timescale 1ns/1ps
module tdc_read_sel
  import tdc_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0]         nonempty,
  input  logic [NUM_CH-1:0]         one_left,
  input  stamp_t [NUM_CH-1:0]       head,
  input  logic                      fire,
  output logic [WORD_W-1:0]         word,
  output logic [NUM_CH-1:0]         pop_vec
);
  logic [CHAN_W-1:0] sel;
  logic              any;
  logic              last;

  always_comb begin
    sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (nonempty[i]) sel = CHAN_W'(i);
    end
    any  = |nonempty;
    last = any && ($countones(nonempty) == 1) && one_left[sel];
    if (any)
      word = pack_word(last, 1'b0, sel, head[sel]);
    else
      word = pack_word(1'b1, 1'b1, '0, '0);
    pop_vec = (fire && any) ? (NUM_CH'(1) << sel) : '0;
  end
endmodule

// File: rtl/tdc_multihit.sv
`timescale 1ns/1ps
module tdc_multihit
  import tdc_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int DEPTH       = 8,
  parameter int DEAD_CYCLES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gate_open,
  input  logic [NUM_CH-1:0]        hit_in,
  input  logic [NUM_CH*FINE_W-1:0] fine_in,
  input  logic [NUM_CH-1:0]        fine_under,
  input  logic [NUM_CH-1:0]        fine_over,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [WORD_W-1:0]        rd_data,
  output logic [NUM_CH-1:0]        chan_empty,
  output logic [NUM_CH-1:0]        chan_ovf,
  output logic [NUM_CH-1:0]        wr_pulse
);
  logic [COARSE_W-1:0]  coarse_q;
  logic                 valid_q;
  logic [NUM_CH-1:0]    take_vec, drop_vec, full_vec, one_vec, pop_vec;
  stamp_t [NUM_CH-1:0]  head_vec;
  stamp_t [NUM_CH-1:0]  stamp_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= '0;
      valid_q  <= 1'b0;
      chan_ovf <= '0;
      wr_pulse <= '0;
    end else begin
      coarse_q <= coarse_q + 1'b1;
      valid_q  <= 1'b1;
      chan_ovf <= chan_ovf | drop_vec;
      wr_pulse <= take_vec;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      always_comb begin
        stamp_vec[i].over   = fine_over[i];
        stamp_vec[i].under  = fine_under[i];
        stamp_vec[i].coarse = coarse_q;
        stamp_vec[i].fine   = fine_in[i*FINE_W +: FINE_W];
      end

      tdc_edge_arm #(.DEAD_CYCLES(DEAD_CYCLES)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_in    (hit_in[i]),
        .gate_open (gate_open),
        .fifo_full (full_vec[i]),
        .take      (take_vec[i]),
        .drop      (drop_vec[i])
      );

      tdc_hit_fifo #(.DEPTH(DEPTH), .W(STAMP_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_vec[i]),
        .din      (stamp_vec[i]),
        .pop      (pop_vec[i]),
        .dout     (head_vec[i]),
        .empty    (chan_empty[i]),
        .full     (full_vec[i]),
        .one_left (one_vec[i])
      );
    end
  endgenerate

  tdc_read_sel #(.NUM_CH(NUM_CH)) u_sel (
    .nonempty (~chan_empty),
    .one_left (one_vec),
    .head     (head_vec),
    .fire     (rd_valid & rd_ready),
    .word     (rd_data),
    .pop_vec  (pop_vec)
  );

  assign rd_valid = valid_q;

  assert_gate_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> !(|wr_pulse));
  assert_hold_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && !(|take_vec)) |=> $stable(rd_data));
  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop_vec) |=> (|chan_ovf));
  assert_last_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_data[BIT_LAST] && !rd_data[BIT_INVALID] && !(|take_vec))
      |=> (&chan_empty));
endmodule

// File: tb/tdc_multihit_bench.sv
`timescale 1ns/1ps
module tdc_multihit_bench;
  localparam int NCH = 16;
  localparam logic [31:0] NODATA = 32'h8200_0000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            gate_open;
  logic [NCH-1:0]  hit_in;
  logic [NCH*5-1:0] fine_in;
  logic [NCH-1:0]  fine_under, fine_over;
  logic            rd_valid, rd_ready;
  logic [31:0]     rd_data;
  logic [NCH-1:0]  chan_empty, chan_ovf, wr_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [10:0] bcnt;
  logic [31:0] exp_q [NCH][$];

  always #2.5 clk = ~clk;

  tdc_multihit u_tdc_multihit (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .hit_in(hit_in),
    .fine_in(fine_in), .fine_under(fine_under), .fine_over(fine_over),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .chan_empty(chan_empty), .chan_ovf(chan_ovf), .wr_pulse(wr_pulse)
  );

  // model of the coarse counter per R11
  always @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= bcnt + 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int total_left();
    int t = 0;
    for (int c = 0; c < NCH; c++) t += exp_q[c].size();
    return t;
  endfunction

  // driver: one rising edge on line ch, optionally waiting for a coarse value
  task automatic do_hit(input int ch, input int tgt, input logic [4:0] f,
                        input logic u, input logic o, input bit rec, input string req);
    logic [31:0] w;
    if (tgt >= 0) while (int'(bcnt) != tgt) tick();
    hit_in[ch] = 1'b1;
    fine_in[ch*5 +: 5] = f;
    fine_under[ch] = u;
    fine_over[ch]  = o;
    if (rec) begin
      w = '0;
      w[21:18] = 4'(ch);
      w[17] = o;
      w[16] = u;
      w[15:5] = bcnt;
      w[4:0] = f;
      exp_q[ch].push_back(w);
    end
    tick();
    chk(wr_pulse[ch] == rec, req, "write pulse after edge", 32'(wr_pulse[ch]), 32'(rec));
    hit_in[ch] = 1'b0;
    tick();
    chk(wr_pulse == '0, "R2", "write pulse is one cycle", 32'(wr_pulse), 32'h0);
  endtask

  // monitor: compares every transfer against the scoreboard
  int mon_ch;
  int mon_tot;
  logic [31:0] mon_exp;
  string mon_req;
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      mon_ch = -1;
      mon_tot = total_left();
      for (int c = NCH - 1; c >= 0; c--) if (exp_q[c].size() > 0) mon_ch = c;
      if (mon_ch < 0) begin
        mon_exp = NODATA;
        mon_req = "R9";
      end else begin
        mon_exp = exp_q[mon_ch].pop_front();
        if (mon_tot == 1) mon_exp[31] = 1'b1;
        mon_req = (mon_tot == 1) ? "R8" : "R6 R7";
      end
      chk(rd_data == mon_exp, mon_req, "stream word", rd_data, mon_exp);
    end
  end

  task automatic drain();
    rd_ready = 1'b1;
    while (total_left() > 0) tick();
    rd_ready = 1'b0;
    tick();
    chk(chan_empty == '1, "R10", "all empty after drain", 32'(chan_empty), 32'hFFFF);
    chk(rd_data == NODATA, "R9", "no-data word after drain", rd_data, NODATA);
  endtask

  initial begin
    int c;
    logic [31:0] held;
    rst_n = 1'b0; gate_open = 1'b0; hit_in = '0; fine_in = '0;
    fine_under = '0; fine_over = '0; rd_ready = 1'b0;
    repeat (3) tick();
    // R1 reset state
    chk(chan_empty == '1, "R1", "empty in reset", 32'(chan_empty), 32'hFFFF);
    chk(chan_ovf == '0, "R1", "ovf in reset", 32'(chan_ovf), 32'h0);
    chk(wr_pulse == '0, "R1", "pulse in reset", 32'(wr_pulse), 32'h0);
    chk(rd_data == NODATA, "R1", "word in reset", rd_data, NODATA);
    chk(rd_valid == 1'b0, "R1", "valid in reset", 32'(rd_valid), 32'h0);
    rst_n = 1'b1;
    tick();
    chk(rd_valid == 1'b1, "R1", "valid after reset", 32'(rd_valid), 32'h1);
    gate_open = 1'b1;

    // R2 R7 several lines with flag patterns
    do_hit(3, -1, 5'd17, 1'b0, 1'b0, 1'b1, "R2");
    do_hit(12, -1, 5'd31, 1'b1, 1'b0, 1'b1, "R2");
    do_hit(1, -1, 5'd0, 1'b0, 1'b1, 1'b1, "R7");
    do_hit(3, (int'(bcnt) + 8) % 2048, 5'd9, 1'b1, 1'b1, 1'b1, "R7");
    chk(chan_empty[3] == 1'b0, "R10", "line 3 non-empty", 32'(chan_empty[3]), 32'h0);

    // R3 gate closed
    gate_open = 1'b0;
    do_hit(2, -1, 5'd4, 1'b0, 1'b0, 1'b0, "R3");
    chk(chan_empty[2] == 1'b1, "R3", "line 2 untouched", 32'(chan_empty[2]), 32'h1);
    gate_open = 1'b1;
    do_hit(2, -1, 5'd6, 1'b0, 1'b0, 1'b1, "R3");

    // R4 blind window boundary
    c = int'(bcnt);
    do_hit(5, -1, 5'd1, 1'b0, 1'b0, 1'b1, "R4");
    do_hit(5, (c + 6) % 2048, 5'd2, 1'b0, 1'b0, 1'b0, "R4");
    c = int'(bcnt);
    do_hit(6, -1, 5'd3, 1'b0, 1'b0, 1'b1, "R4");
    do_hit(6, (c + 7) % 2048, 5'd7, 1'b0, 1'b0, 1'b1, "R4");

    // R12 back-pressure hold
    held = rd_data;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(rd_data == held, "R12", "word held while not ready", rd_data, held);
    end

    // R6 R8 drain
    drain();

    // R9 reads of the no-data word
    rd_ready = 1'b1;
    tick(); tick();
    rd_ready = 1'b0;
    tick();
    chk(chan_empty == '1, "R9", "no-data transfer changes nothing", 32'(chan_empty), 32'hFFFF);

    // R5 capacity and sticky overflow
    c = int'(bcnt);
    for (int k = 0; k < 9; k++) begin
      do_hit(9, (c + 8 * k) % 2048, 5'(k + 10), 1'b0, 1'b0, (k < 8), "R5");
    end
    chk(chan_ovf == 16'h0200, "R5", "overflow flag set", 32'(chan_ovf), 32'h0200);
    drain();
    chk(chan_ovf == 16'h0200, "R5", "overflow flag sticky", 32'(chan_ovf), 32'h0200);

    // R11 coarse wrap
    do_hit(0, 2047, 5'd21, 1'b0, 1'b0, 1'b1, "R11");
    do_hit(1, 3, 5'd22, 1'b0, 1'b0, 1'b1, "R11");
    drain();

    // R1 reset mid-run
    do_hit(4, -1, 5'd5, 1'b0, 1'b0, 1'b1, "R2");
    rst_n = 1'b0;
    tick(); tick();
    chk(chan_empty == '1, "R1", "empty after reset", 32'(chan_empty), 32'hFFFF);
    chk(chan_ovf == '0, "R1", "ovf cleared by reset", 32'(chan_ovf), 32'h0);
    chk(rd_data == NODATA, "R1", "word after reset", rd_data, NODATA);
    exp_q[4].delete();
    rst_n = 1'b1;
    tick();
    do_hit(15, -1, 5'd30, 1'b1, 1'b0, 1'b1, "R11");
    do_hit(8, -1, 5'd11, 1'b0, 1'b1, 1'b1, "R6");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule